// File: doc/BRIEF.md
# Deadtime and Control-Band Allocator

This block turns one signed output of a voltage-loop compensator into two actuator commands for a resonant half-bridge converter: a control-band value and a primary deadtime value. The sign of the command picks the actuator. A positive command raises the control band above its floor and keeps the deadtime at its floor. A negative command keeps the control band at its floor and raises the deadtime by an amount proportional to the size of the command. Each path has an unsigned fixed-point gain with four fraction bits. Each path also has a programmable floor and ceiling.

The two paths handle their ceilings differently. The control band saturates at its ceiling and raises a flag, which slope-compensation logic elsewhere uses to step the slope down. The deadtime also saturates at its ceiling. If the computed deadtime goes past that ceiling, the block also raises a PWM-off request. The ceiling therefore works as a minimum on-time limit, and when the command goes beyond it switching stops and the converter drops into burst operation. All outputs are registered and change only on a sample strobe.

Top module: `band_dt_alloc`

## Requirements
- R1: When the command is positive, on a sample the deadtime output equals `dt_min` and the band output equals min(`band_min` + ((cmd × `band_gain`) >> 4), `band_max`).
- R2: When the command is negative, on a sample the band output equals `band_min` and the deadtime output equals min(`dt_min` + ((|cmd| × `dt_gain`) >> 4), `dt_max`), where |cmd| of the most negative value is 2^(CMD_W-1).
- R3: A command of exactly zero gives `band_min` on the band output and `dt_min` on the deadtime output, with both flags low (given min < max on both paths).
- R4: `pwm_off` is high after a sample whose computed deadtime (before saturation) is strictly greater than `dt_max`. The deadtime output then equals `dt_max`.
- R5: The band output never wraps. For any gain and command it stays at or below `band_max`.
- R6: `band_at_max` is high after a sample whose computed band value (before saturation) is greater than or equal to `band_max`, and low otherwise.
- R7: Outputs load on the clock edge where `sample_stb` is high, so they are visible one cycle after the strobe. They hold their values while the strobe is low, whatever the other inputs do.
- R8: `pwm_off` clears on the first sample whose computed deadtime is equal to or below `dt_max`. A deadtime exactly equal to `dt_max` does not request PWM-off.
- R9: Synchronous active-high reset clears all four outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | Sample strobe; outputs load on this edge |
| comp_cmd | input | CMD_W | Signed compensator output |
| band_min | input | OUT_W | Control-band floor |
| band_max | input | OUT_W | Control-band ceiling |
| band_gain | input | GAIN_W | Band path gain, unsigned, 4 fraction bits |
| dt_min | input | OUT_W | Deadtime floor |
| dt_max | input | OUT_W | Deadtime ceiling (minimum on-time limit) |
| dt_gain | input | GAIN_W | Deadtime path gain, unsigned, 4 fraction bits |
| band_out | output | OUT_W | Control-band command |
| dt_out | output | OUT_W | Deadtime command |
| pwm_off | output | 1 | PWM-off request (burst cutoff) |
| band_at_max | output | 1 | Control band at ceiling |

## Verification
Random commands with random limits and gains cover both signs. A wrong sign steer is exposed because the idle path must stay exactly at its floor. The directed cases are:
- Zero and the most negative command, which separate the boundary of the sign test from the magnitude conversion.
- A deadtime that lands exactly on the ceiling and one that lands one step past it, which pin down the strict comparison behind the PWM-off request and its release.
- A full-scale positive command at full gain, which separates saturation from wrap-around on the band path.
- Input changes without a strobe, which show the outputs hold.

// File: rtl/bda_pkg.sv
package bda_pkg;
  localparam int NUM_LANES = 2;
  typedef enum logic {
    LANE_BAND = 1'b0,
    LANE_DT   = 1'b1
  } lane_e;
endpackage

// File: rtl/bda_sign_split.sv
module bda_sign_split #(
  parameter int CMD_W = 16
) (
  input  logic [CMD_W-1:0] cmd,
  output logic             is_pos,
  output logic             is_neg,
  output logic [CMD_W-1:0] mag
);
  always_comb begin
    is_neg = cmd[CMD_W-1];
    is_pos = ~cmd[CMD_W-1] & (|cmd);
    // Two's complement magnitude; the most negative value maps to 2^(CMD_W-1)
    mag    = is_neg ? (~cmd + {{(CMD_W-1){1'b0}}, 1'b1}) : cmd;
  end
endmodule

// File: rtl/bda_scale.sv
module bda_scale #(
  parameter int CMD_W  = 16,
  parameter int GAIN_W = 8,
  parameter int FRAC_W = 4,
  localparam int FULL_W = CMD_W + GAIN_W,
  localparam int PROD_W = FULL_W - FRAC_W
) (
  input  logic              active,
  input  logic [CMD_W-1:0]  mag,
  input  logic [GAIN_W-1:0] gain,
  output logic [PROD_W-1:0] scaled
);
  logic [FULL_W-1:0] full;

  always_comb begin
    full   = {{GAIN_W{1'b0}}, mag} * {{CMD_W{1'b0}}, gain};
    scaled = active ? full[FULL_W-1:FRAC_W] : '0;
  end
endmodule

// File: rtl/bda_limit.sv
module bda_limit #(
  parameter int OUT_W  = 12,
  parameter int PROD_W = 20,
  localparam int SUM_W = ((PROD_W > OUT_W) ? PROD_W : OUT_W) + 1
) (
  input  logic [OUT_W-1:0]  base,
  input  logic [OUT_W-1:0]  lim,
  input  logic [PROD_W-1:0] scaled,
  output logic [OUT_W-1:0]  value,
  output logic              over,
  output logic              at_lim
);
  logic [SUM_W-1:0] raw;
  logic [SUM_W-1:0] lim_ext;

  always_comb begin
    raw     = {{(SUM_W-PROD_W){1'b0}}, scaled} + {{(SUM_W-OUT_W){1'b0}}, base};
    lim_ext = {{(SUM_W-OUT_W){1'b0}}, lim};
    over    = raw > lim_ext;
    at_lim  = raw >= lim_ext;
    value   = over ? lim : raw[OUT_W-1:0];
  end
endmodule

// File: rtl/band_dt_alloc.sv
module band_dt_alloc
  import bda_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int OUT_W  = 12,
  parameter int GAIN_W = 8,
  parameter int FRAC_W = 4,
  localparam int PROD_W = CMD_W + GAIN_W - FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_stb,
  input  logic [CMD_W-1:0]  comp_cmd,
  input  logic [OUT_W-1:0]  band_min,
  input  logic [OUT_W-1:0]  band_max,
  input  logic [GAIN_W-1:0] band_gain,
  input  logic [OUT_W-1:0]  dt_min,
  input  logic [OUT_W-1:0]  dt_max,
  input  logic [GAIN_W-1:0] dt_gain,
  output logic [OUT_W-1:0]  band_out,
  output logic [OUT_W-1:0]  dt_out,
  output logic              pwm_off,
  output logic              band_at_max
);
  logic             cmd_pos, cmd_neg;
  logic [CMD_W-1:0] cmd_mag;

  logic [OUT_W-1:0]  lane_base  [NUM_LANES];
  logic [OUT_W-1:0]  lane_lim   [NUM_LANES];
  logic [GAIN_W-1:0] lane_gain  [NUM_LANES];
  logic              lane_act   [NUM_LANES];
  logic [PROD_W-1:0] lane_scl   [NUM_LANES];
  logic [OUT_W-1:0]  lane_val   [NUM_LANES];
  logic              lane_over  [NUM_LANES];
  logic              lane_atlim [NUM_LANES];

  bda_sign_split #(.CMD_W(CMD_W)) u_split (
    .cmd    (comp_cmd),
    .is_pos (cmd_pos),
    .is_neg (cmd_neg),
    .mag    (cmd_mag)
  );

  // Steering: band path runs on positive commands, deadtime path on negative
  always_comb begin
    lane_base[LANE_BAND] = band_min;
    lane_lim [LANE_BAND] = band_max;
    lane_gain[LANE_BAND] = band_gain;
    lane_act [LANE_BAND] = cmd_pos;
    lane_base[LANE_DT]   = dt_min;
    lane_lim [LANE_DT]   = dt_max;
    lane_gain[LANE_DT]   = dt_gain;
    lane_act [LANE_DT]   = cmd_neg;
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    bda_scale #(
      .CMD_W  (CMD_W),
      .GAIN_W (GAIN_W),
      .FRAC_W (FRAC_W)
    ) u_scale (
      .active (lane_act[i]),
      .mag    (cmd_mag),
      .gain   (lane_gain[i]),
      .scaled (lane_scl[i])
    );

    bda_limit #(
      .OUT_W  (OUT_W),
      .PROD_W (PROD_W)
    ) u_limit (
      .base   (lane_base[i]),
      .lim    (lane_lim[i]),
      .scaled (lane_scl[i]),
      .value  (lane_val[i]),
      .over   (lane_over[i]),
      .at_lim (lane_atlim[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      band_out    <= '0;
      dt_out      <= '0;
      pwm_off     <= 1'b0;
      band_at_max <= 1'b0;
    end else if (sample_stb) begin
      band_out    <= lane_val[LANE_BAND];
      dt_out      <= lane_val[LANE_DT];
      pwm_off     <= lane_over[LANE_DT];
      band_at_max <= lane_atlim[LANE_BAND];
    end
  end
endmodule

// File: rtl/band_dt_alloc_checker.sv
module band_dt_alloc_checker #(
  parameter int CMD_W = 16,
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_stb,
  input logic [CMD_W-1:0] comp_cmd,
  input logic [OUT_W-1:0] band_min,
  input logic [OUT_W-1:0] band_max,
  input logic [OUT_W-1:0] dt_min,
  input logic [OUT_W-1:0] dt_max,
  input logic [OUT_W-1:0] band_out,
  input logic [OUT_W-1:0] dt_out,
  input logic             pwm_off,
  input logic             band_at_max
);
  AST_POS_DT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && !comp_cmd[CMD_W-1] && dt_min <= dt_max)
      |=> (dt_out == $past(dt_min) && !pwm_off)); // R1

  AST_NEG_BAND_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && comp_cmd[CMD_W-1] && band_min < band_max)
      |=> (band_out == $past(band_min) && !band_at_max)); // R2

  AST_OFF_AT_CEIL: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> (!pwm_off || dt_out == $past(dt_max))); // R4

  AST_BAND_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> (band_out <= $past(band_max))); // R5

  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> ($stable(band_out) && $stable(dt_out)
                     && $stable(pwm_off) && $stable(band_at_max))); // R7
endmodule

bind band_dt_alloc band_dt_alloc_checker #(
  .CMD_W (CMD_W),
  .OUT_W (OUT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sample_stb  (sample_stb),
  .comp_cmd    (comp_cmd),
  .band_min    (band_min),
  .band_max    (band_max),
  .dt_min      (dt_min),
  .dt_max      (dt_max),
  .band_out    (band_out),
  .dt_out      (dt_out),
  .pwm_off     (pwm_off),
  .band_at_max (band_at_max)
);

// File: tb/band_dt_alloc_tb.sv
module band_dt_alloc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_stb = 1'b0;
  logic [15:0] comp_cmd = '0;
  logic [11:0] band_min = '0, band_max = '0, dt_min = '0, dt_max = '0;
  logic [7:0]  band_gain = '0, dt_gain = '0;
  logic [11:0] band_out, dt_out;
  logic        pwm_off, band_at_max;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  band_dt_alloc u_dut (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .comp_cmd(comp_cmd),
    .band_min(band_min), .band_max(band_max), .band_gain(band_gain),
    .dt_min(dt_min), .dt_max(dt_max), .dt_gain(dt_gain),
    .band_out(band_out), .dt_out(dt_out), .pwm_off(pwm_off),
    .band_at_max(band_at_max)
  );

  longint e_band, e_dt;
  logic   e_off, e_flag;

  function automatic longint to_signed(logic [15:0] c);
    return c[15] ? longint'(c) - 65536 : longint'(c);
  endfunction

  // Reference model built from the requirements
  task automatic model();
    longint c = to_signed(comp_cmd);
    longint braw = band_min;
    longint draw = dt_min;
    if (c > 0) braw = band_min + ((c * band_gain) >> 4);
    if (c < 0) draw = dt_min + (((-c) * dt_gain) >> 4);
    e_band = (braw > band_max) ? band_max : braw;
    e_flag = (braw >= band_max);
    e_dt   = (draw > dt_max) ? dt_max : draw;
    e_off  = (draw > dt_max);
  endtask

  task automatic check_all(string tag);
    n_chk++;
    if (band_out !== e_band[11:0] || dt_out !== e_dt[11:0] ||
        pwm_off !== e_off || band_at_max !== e_flag) begin
      n_fail++;
      $display("FAIL %s: band=%0d dt=%0d off=%0b flag=%0b expected band=%0d dt=%0d off=%0b flag=%0b",
               tag, band_out, dt_out, pwm_off, band_at_max, e_band, e_dt, e_off, e_flag);
    end
  endtask

  // Drive at negedge, strobe for one edge, check at the following negedge
  task automatic sample(string tag);
    model();
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    check_all(tag);
  endtask

  task automatic set_lim(int bmn, int bmx, int bg, int dmn, int dmx, int dg);
    band_min = 12'(bmn); band_max = 12'(bmx); band_gain = 8'(bg);
    dt_min = 12'(dmn); dt_max = 12'(dmx); dt_gain = 8'(dg);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    set_lim(100, 2000, 16, 50, 400, 16);
    comp_cmd = 16'd300;
    repeat (3) @(negedge clk);
    // R9: reset state even with inputs driven
    e_band = 0; e_dt = 0; e_off = 0; e_flag = 0;
    check_all("R9");
    rst = 1'b0;
    @(negedge clk);

    // R3: zero command
    comp_cmd = 16'd0;
    sample("R3");

    // R1: positive, gain 1.0
    comp_cmd = 16'd300;
    sample("R1");

    // R2: negative, gain 1.0
    comp_cmd = -16'sd200;
    sample("R2");

    // R7: no strobe, inputs change, outputs hold previous sample
    comp_cmd = 16'd1000; band_min = 12'd7; dt_min = 12'd9;
    @(negedge clk);
    @(negedge clk);
    check_all("R7");

    // R4: deadtime past ceiling -> PWM-off, output at ceiling
    set_lim(100, 2000, 16, 50, 400, 16);
    comp_cmd = -16'sd351;
    sample("R4");

    // R8: exactly at ceiling clears PWM-off
    comp_cmd = -16'sd350;
    sample("R8");

    // R4: one past, then R8 release from a deeper overflow
    comp_cmd = -16'sd5000;
    sample("R4");
    comp_cmd = -16'sd10;
    sample("R8");

    // R5: full-scale positive at full gain, no wrap
    set_lim(10, 4095, 255, 0, 4095, 255);
    comp_cmd = 16'h7FFF;
    sample("R5");

    // R2: most negative command magnitude
    set_lim(10, 4000, 1, 3, 4095, 1);
    comp_cmd = 16'h8000;
    sample("R2");

    // R6: band exactly at ceiling, then one below
    set_lim(100, 400, 16, 0, 100, 16);
    comp_cmd = 16'd300;
    sample("R6");
    comp_cmd = 16'd299;
    sample("R6");

    // Random mix across both signs
    for (int k = 0; k < 400; k++) begin
      int bmn = $urandom_range(0, 1000);
      int dmn = $urandom_range(0, 1000);
      set_lim(bmn, $urandom_range(bmn + 1, 4095), $urandom_range(0, 255),
              dmn, $urandom_range(dmn + 1, 4095), $urandom_range(0, 255));
      comp_cmd = 16'($urandom);
      if (k % 5 == 0) comp_cmd = 16'($signed(16'($urandom_range(0, 600))) - 300);
      if (comp_cmd[15])            sample("R2");
      else if (comp_cmd == 16'd0)  sample("R3");
      else                         sample("R1");
      if ($urandom_range(0, 3) == 0) begin
        comp_cmd = 16'($urandom);
        @(negedge clk);
        check_all("R7");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule